// File: doc/BRIEF.md
# Snooping Cache Line Coherence Controller

This block keeps the coherence state of one cache line in a processor cache that sits on an atomic snooping bus. It holds the line's address tag and one of four stable states: invalid, shared, exclusive or modified. It also has four waiting states. The controller sits in a waiting state from the moment it raises a bus request until the arbiter grants it. These states exist because ownership is not settled until the request actually reaches the bus.

On the processor side, a read or write request is held high together with a line address until `cpu_done_o` is seen. A hit completes in the cycle the request is accepted. A miss, or a write to a shared copy, becomes a bus request. The request carries a command and the line address. When the line must be evicted while dirty, it is written back before the fetch starts.

On the bus side, the controller snoops every transaction, even while it waits for its own grant. It supplies dirty data through `flush_o` and downgrades or drops its copy. A pending upgrade that sees another cache take ownership of the same block first drops its copy and turns into a read-for-ownership. A write that wins the bus is committed in that same cycle, so a later snoop cannot take the line away before the write lands.

Top module: `mesi_line_ctrl`

## Requirements
- R1: After reset, `line_state_o` is 0 (invalid). While reset is held, `bus_req_o`, `flush_o` and `cpu_done_o` are low.
- R2: A read miss moves the line to the read-pending state (4). It raises `bus_req_o` with command 0 (read) and the miss address, and holds `cpu_done_o` low until grant. In the grant cycle `cpu_done_o` is high. The line then becomes exclusive (2) if `bus_shared_i` is low in that cycle, or shared (1) if it is high.
- R3: A read hit in shared, exclusive or modified completes in the same cycle with no bus request. A write hit in exclusive (2) completes in the same cycle, raises no bus request, and moves the line to modified (3).
- R4: A write hit in shared moves the line to the upgrade-pending state (6) and requests the bus with command 2 (upgrade). `cpu_done_o` stays low until grant. The grant cycle completes the write, and the line becomes modified.
- R5: While upgrade-pending, a snooped read-for-ownership (1) or upgrade (2) to the same address moves the line to the write-pending state (5) with command 1, with no flush. The request then completes as a write miss.
- R6: A write miss moves the line to write-pending (5) and requests command 1 (read-for-ownership) with the miss address. The grant cycle completes the write, and the line becomes modified.
- R7: A snooped read (0) that hits a modified line raises `flush_o` in that cycle and moves the line to shared. A snooped read-for-ownership (1) raises `flush_o` and moves the line to invalid.
- R8: A snooped read-for-ownership or upgrade that hits a shared or exclusive line moves it to invalid without a flush. A snooped read that hits an exclusive line moves it to shared.
- R9: A snoop to any other address leaves the state unchanged and gives no flush, in stable and in pending states alike.
- R10: A miss while the line is modified under another address enters the write-back-pending state (7). It requests command 3 with the old address. On grant, `flush_o` is high and `cpu_done_o` low, and the controller then requests the fetch for the new address.
- R11: While write-back-pending, a snoop hitting the old dirty address raises `flush_o`. The write-back is then skipped, and the fetch for the new address is requested next.
- R12: Grants and snoops never coincide. A write completes in its grant cycle, so a conflicting snoop in the very next cycle finds the line modified and flushes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_rd_i | input | 1 | Processor read request, held until done |
| cpu_wr_i | input | 1 | Processor write request, held until done |
| cpu_addr_i | input | ADDR_W | Processor line address |
| cpu_done_o | output | 1 | Request completes at the coming edge |
| bus_req_o | output | 1 | Bus request |
| bus_cmd_o | output | 2 | Command: 0 read, 1 read-for-ownership, 2 upgrade, 3 write-back |
| bus_addr_o | output | ADDR_W | Address of the requested transaction |
| bus_gnt_i | input | 1 | Grant; the transaction occupies the bus this cycle |
| bus_shared_i | input | 1 | Another cache holds the block (valid in read grant cycle) |
| snp_valid_i | input | 1 | Another cache's transaction is on the bus |
| snp_cmd_i | input | 2 | Snooped command, same encoding as bus_cmd_o |
| snp_addr_i | input | ADDR_W | Snooped line address |
| flush_o | output | 1 | This cache drives the dirty line onto the bus |
| line_state_o | output | 3 | 0 I, 1 S, 2 E, 3 M, 4 read-pend, 5 write-pend, 6 upgrade-pend, 7 write-back-pend |

## Verification
The hardest case is the lost upgrade. A write to a shared line must be waiting without a grant when another cache's ownership request for the same block appears on the bus. The bench fills the line shared through a read with the shared signal high. It then raises a write and keeps the grant low for a cycle. In that window it injects the conflicting snoop. After that it grants and checks that the request has become a read-for-ownership that ends in modified. The write-back window is reached the same way. A dirty line is first left under one address, and a miss to another address then opens the window, with no grant given yet.

// File: rtl/mesi_pkg.sv
package mesi_pkg;
  typedef enum logic [2:0] {
    ST_I  = 3'd0,
    ST_S  = 3'd1,
    ST_E  = 3'd2,
    ST_M  = 3'd3,
    ST_IS = 3'd4,  // read miss waiting for grant
    ST_IM = 3'd5,  // write miss waiting for grant
    ST_SM = 3'd6,  // upgrade waiting for grant
    ST_WB = 3'd7   // dirty eviction waiting for grant
  } line_st_e;

  typedef enum logic [1:0] {
    CMD_RD   = 2'd0,
    CMD_RDX  = 2'd1,
    CMD_UPGR = 2'd2,
    CMD_WB   = 2'd3
  } bus_cmd_e;

  function automatic logic st_waiting(line_st_e s);
    return s[2];
  endfunction

  function automatic logic st_has_copy(line_st_e s);
    return (s == ST_S) || (s == ST_E) || (s == ST_M) || (s == ST_SM) || (s == ST_WB);
  endfunction
endpackage

// File: rtl/mesi_tag_cmp.sv
module mesi_tag_cmp
  import mesi_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  line_st_e          state_i,
  input  logic [ADDR_W-1:0] tag_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic              snp_valid_i,
  input  logic [ADDR_W-1:0] snp_addr_i,
  output logic              cpu_hit_o,
  output logic              snp_hit_o
);
  logic stable_valid;

  assign stable_valid = (state_i == ST_S) || (state_i == ST_E) || (state_i == ST_M);
  assign cpu_hit_o    = stable_valid && (tag_i == cpu_addr_i);
  // pending fills hold the new tag but no data, so they do not answer snoops
  assign snp_hit_o    = snp_valid_i && st_has_copy(state_i) && (tag_i == snp_addr_i);
endmodule

// File: rtl/mesi_next_state.sv
module mesi_next_state
  import mesi_pkg::*;
(
  input  line_st_e state_i,
  input  logic     cpu_rd_i,
  input  logic     cpu_wr_i,
  input  logic     cpu_hit_i,
  input  logic     snp_hit_i,
  input  bus_cmd_e snp_cmd_i,
  input  logic     bus_gnt_i,
  input  logic     bus_shared_i,
  input  logic     pend_wr_i,
  output line_st_e state_o,
  output logic     flush_o,
  output logic     done_o,
  output logic     tag_from_cpu_o,
  output logic     tag_from_pend_o,
  output logic     pend_load_o
);
  line_st_e after_wb;

  assign after_wb = pend_wr_i ? ST_IM : ST_IS;

  always_comb begin
    state_o         = state_i;
    flush_o         = 1'b0;
    done_o          = 1'b0;
    tag_from_cpu_o  = 1'b0;
    tag_from_pend_o = 1'b0;
    pend_load_o     = 1'b0;
    if (st_waiting(state_i) && bus_gnt_i) begin
      case (state_i)
        ST_IS: begin
          state_o = bus_shared_i ? ST_S : ST_E;
          done_o  = 1'b1;
        end
        ST_IM, ST_SM: begin
          state_o = ST_M;  // write lands in the grant cycle: ownership cannot be lost first
          done_o  = 1'b1;
        end
        default: begin  // ST_WB
          flush_o         = 1'b1;
          state_o         = after_wb;
          tag_from_pend_o = 1'b1;
        end
      endcase
    end else if (snp_hit_i) begin
      case (state_i)
        ST_M: begin
          if (snp_cmd_i == CMD_RD) begin
            flush_o = 1'b1;
            state_o = ST_S;
          end else if (snp_cmd_i == CMD_RDX) begin
            flush_o = 1'b1;
            state_o = ST_I;
          end
        end
        ST_E: state_o = (snp_cmd_i == CMD_RD) ? ST_S : ST_I;
        ST_S: if (snp_cmd_i != CMD_RD) state_o = ST_I;
        ST_SM: if (snp_cmd_i != CMD_RD) state_o = ST_IM;  // lost race: fetch with ownership
        ST_WB: begin
          if (snp_cmd_i != CMD_UPGR) begin
            // dirty data leaves now; eviction no longer needed
            flush_o         = 1'b1;
            state_o         = after_wb;
            tag_from_pend_o = 1'b1;
          end
        end
        default: ;
      endcase
    end else if (!st_waiting(state_i) && (cpu_rd_i || cpu_wr_i)) begin
      if (cpu_hit_i) begin
        if (cpu_wr_i) begin
          if (state_i == ST_S) begin
            state_o = ST_SM;
          end else begin
            state_o = ST_M;
            done_o  = 1'b1;
          end
        end else begin
          done_o = 1'b1;
        end
      end else if (state_i == ST_M) begin
        state_o     = ST_WB;
        pend_load_o = 1'b1;
      end else begin
        state_o        = cpu_wr_i ? ST_IM : ST_IS;
        tag_from_cpu_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/mesi_bus_drv.sv
module mesi_bus_drv
  import mesi_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  line_st_e          state_i,
  input  logic [ADDR_W-1:0] tag_i,
  output logic              req_o,
  output bus_cmd_e          cmd_o,
  output logic [ADDR_W-1:0] addr_o
);
  assign req_o  = st_waiting(state_i);
  assign addr_o = tag_i;

  always_comb begin
    case (state_i)
      ST_IM:   cmd_o = CMD_RDX;
      ST_SM:   cmd_o = CMD_UPGR;
      ST_WB:   cmd_o = CMD_WB;
      default: cmd_o = CMD_RD;
    endcase
  end
endmodule

// File: rtl/mesi_line_ctrl.sv
module mesi_line_ctrl
  import mesi_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_rd_i,
  input  logic              cpu_wr_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  output logic              cpu_done_o,
  output logic              bus_req_o,
  output logic [1:0]        bus_cmd_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  input  logic              bus_gnt_i,
  input  logic              bus_shared_i,
  input  logic              snp_valid_i,
  input  logic [1:0]        snp_cmd_i,
  input  logic [ADDR_W-1:0] snp_addr_i,
  output logic              flush_o,
  output logic [2:0]        line_state_o
);
  line_st_e          state_q, state_d;
  logic [ADDR_W-1:0] tag_q, pend_addr_q;
  logic              pend_wr_q;
  logic              cpu_hit, snp_hit;
  logic              tag_from_cpu, tag_from_pend, pend_load;
  bus_cmd_e          cmd;

  mesi_tag_cmp #(.ADDR_W(ADDR_W)) u_tag (
    .state_i    (state_q),
    .tag_i      (tag_q),
    .cpu_addr_i (cpu_addr_i),
    .snp_valid_i(snp_valid_i),
    .snp_addr_i (snp_addr_i),
    .cpu_hit_o  (cpu_hit),
    .snp_hit_o  (snp_hit)
  );

  mesi_next_state u_ns (
    .state_i        (state_q),
    .cpu_rd_i       (cpu_rd_i),
    .cpu_wr_i       (cpu_wr_i),
    .cpu_hit_i      (cpu_hit),
    .snp_hit_i      (snp_hit),
    .snp_cmd_i      (bus_cmd_e'(snp_cmd_i)),
    .bus_gnt_i      (bus_gnt_i),
    .bus_shared_i   (bus_shared_i),
    .pend_wr_i      (pend_wr_q),
    .state_o        (state_d),
    .flush_o        (flush_o),
    .done_o         (cpu_done_o),
    .tag_from_cpu_o (tag_from_cpu),
    .tag_from_pend_o(tag_from_pend),
    .pend_load_o    (pend_load)
  );

  mesi_bus_drv #(.ADDR_W(ADDR_W)) u_bus (
    .state_i(state_q),
    .tag_i  (tag_q),
    .req_o  (bus_req_o),
    .cmd_o  (cmd),
    .addr_o (bus_addr_o)
  );

  assign bus_cmd_o    = cmd;
  assign line_state_o = state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_I;
      tag_q       <= '0;
      pend_addr_q <= '0;
      pend_wr_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (tag_from_cpu)       tag_q <= cpu_addr_i;
      else if (tag_from_pend) tag_q <= pend_addr_q;
      if (pend_load) begin
        pend_addr_q <= cpu_addr_i;
        pend_wr_q   <= cpu_wr_i;
      end
    end
  end

  AST_DONE_NEEDS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_done_o |-> (cpu_rd_i || cpu_wr_i)); // R3
  AST_E_WRITE_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_E && cpu_wr_i && cpu_addr_i == tag_q && !snp_valid_i)
    |=> (state_q == ST_M && !bus_req_o)); // R3
  AST_UPGR_HOLDS_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SM && !bus_gnt_i) |-> !cpu_done_o); // R4
  AST_UPGR_GRANT_M: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SM && bus_gnt_i) |=> state_q == ST_M); // R4
  AST_LOST_UPGR_RDX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SM && !bus_gnt_i && snp_valid_i && snp_addr_i == tag_q &&
     snp_cmd_i != CMD_RD) |=> (state_q == ST_IM && bus_cmd_o == CMD_RDX)); // R5
  AST_WR_MISS_CMD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IM) |-> (bus_req_o && bus_cmd_o == CMD_RDX)); // R6
  AST_M_RD_FLUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_M && snp_valid_i && snp_addr_i == tag_q && snp_cmd_i == CMD_RD)
    |-> flush_o); // R7
  AST_M_RD_TO_S: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_M && snp_valid_i && snp_addr_i == tag_q && snp_cmd_i == CMD_RD)
    |=> state_q == ST_S); // R7
  AST_OTHER_ADDR_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (snp_valid_i && snp_addr_i != tag_q && !cpu_rd_i && !cpu_wr_i) |=> $stable(state_q)); // R9
  AST_WB_GRANT_FLUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WB && bus_gnt_i) |-> (flush_o && !cpu_done_o)); // R10
  AST_BUS_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bus_gnt_i && snp_valid_i)); // R12
endmodule

// File: tb/mesi_line_ctrl_test.sv
`timescale 1ns/1ps
module mesi_line_ctrl_test;
  localparam int AW = 16;
  localparam logic [AW-1:0] A = 16'h1234;
  localparam logic [AW-1:0] B = 16'h0bee;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic cpu_rd, cpu_wr, cpu_done, bus_req, bus_gnt, bus_shared, snp_valid, flush;
  logic [AW-1:0] cpu_addr, bus_addr, snp_addr;
  logic [1:0] bus_cmd, snp_cmd;
  logic [2:0] st;
  int checks = 0, fails = 0;
  bit ended = 0;

  always #5 clk = ~clk;

  mesi_line_ctrl #(.ADDR_W(AW)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .cpu_rd_i(cpu_rd), .cpu_wr_i(cpu_wr),
    .cpu_addr_i(cpu_addr), .cpu_done_o(cpu_done), .bus_req_o(bus_req),
    .bus_cmd_o(bus_cmd), .bus_addr_o(bus_addr), .bus_gnt_i(bus_gnt),
    .bus_shared_i(bus_shared), .snp_valid_i(snp_valid), .snp_cmd_i(snp_cmd),
    .snp_addr_i(snp_addr), .flush_o(flush), .line_state_o(st)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic idle();
    cpu_rd = 0; cpu_wr = 0; cpu_addr = '0; bus_gnt = 0; bus_shared = 0;
    snp_valid = 0; snp_cmd = 0; snp_addr = '0;
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic restart();
    rst_ni = 0; idle(); step(); rst_ni = 1; step();
  endtask

  task automatic fill(input logic [AW-1:0] a, input logic wr, input logic sh);
    cpu_addr = a; cpu_rd = !wr; cpu_wr = wr; step();
    bus_gnt = 1; bus_shared = sh; step(); idle();
  endtask

  task automatic snoop(input logic [1:0] c, input logic [AW-1:0] a);
    snp_valid = 1; snp_cmd = c; snp_addr = a; #1;
  endtask

  task automatic t_reset();
    rst_ni = 0; idle(); #1;
    chk("R1", "req in reset", bus_req, 0);
    chk("R1", "flush in reset", flush, 0);
    chk("R1", "done in reset", cpu_done, 0);
    step(); rst_ni = 1; step();
    chk("R1", "state after reset", st, 0);
  endtask

  task automatic t_read_miss(input logic sh);
    restart();
    cpu_rd = 1; cpu_addr = A; #1;
    chk("R2", "done at miss", cpu_done, 0);
    step();
    chk("R2", "pending state", st, 4);
    chk("R2", "req", bus_req, 1);
    chk("R2", "cmd", bus_cmd, 0);
    chk("R2", "addr", bus_addr, A);
    step();
    chk("R2", "no done without grant", cpu_done, 0);
    bus_gnt = 1; bus_shared = sh; #1;
    chk("R2", "done on grant", cpu_done, 1);
    step(); idle();
    chk("R2", "fill state", st, sh ? 1 : 2);
  endtask

  task automatic t_hits();
    restart(); fill(A, 0, 0);
    cpu_rd = 1; cpu_addr = A; #1;
    chk("R3", "read hit done", cpu_done, 1);
    chk("R3", "read hit no req", bus_req, 0);
    step(); idle();
    chk("R3", "read hit keeps E", st, 2);
    cpu_wr = 1; cpu_addr = A; #1;
    chk("R3", "E write done", cpu_done, 1);
    step(); idle(); #1;
    chk("R3", "E write to M", st, 3);
    chk("R3", "E write no req", bus_req, 0);
    cpu_rd = 1; cpu_addr = A; #1;
    chk("R3", "M read hit done", cpu_done, 1);
    step(); idle();
  endtask

  task automatic t_upgrade();
    restart(); fill(A, 0, 1);
    chk("R4", "filled S", st, 1);
    cpu_wr = 1; cpu_addr = A; #1;
    chk("R4", "no done before ownership", cpu_done, 0);
    step();
    chk("R4", "upgrade pending", st, 6);
    chk("R4", "upgrade cmd", bus_cmd, 2);
    chk("R4", "still no done", cpu_done, 0);
    bus_gnt = 1; #1;
    chk("R4", "done on grant", cpu_done, 1);
    step(); idle();
    chk("R4", "upgrade to M", st, 3);
  endtask

  task automatic t_upgrade_lost(input logic [1:0] c);
    restart(); fill(A, 0, 1);
    cpu_wr = 1; cpu_addr = A; step();
    snoop(c, A);
    chk("R5", "no flush on lost upgrade", flush, 0);
    chk("R5", "no done on lost upgrade", cpu_done, 0);
    step(); snp_valid = 0;
    chk("R5", "converted state", st, 5);
    chk("R5", "converted cmd", bus_cmd, 1);
    chk("R5", "still requesting", bus_req, 1);
    bus_gnt = 1; #1;
    chk("R5", "done after conversion", cpu_done, 1);
    step(); idle();
    chk("R5", "ends in M", st, 3);
  endtask

  task automatic t_write_miss();
    restart();
    cpu_wr = 1; cpu_addr = B; step();
    chk("R6", "write pending", st, 5);
    chk("R6", "cmd rdx", bus_cmd, 1);
    chk("R6", "addr", bus_addr, B);
    bus_gnt = 1; #1;
    chk("R6", "done on grant", cpu_done, 1);
    step(); idle();
    chk("R6", "to M", st, 3);
  endtask

  task automatic t_snoop_m();
    restart(); fill(A, 1, 0);
    snoop(0, A);
    chk("R7", "flush on read", flush, 1);
    step(); idle();
    chk("R7", "M to S", st, 1);
    restart(); fill(A, 1, 0);
    snoop(1, A);
    chk("R7", "flush on rdx", flush, 1);
    step(); idle();
    chk("R7", "M to I", st, 0);
  endtask

  task automatic t_snoop_se();
    restart(); fill(A, 0, 0);
    snoop(0, A);
    chk("R8", "E read no flush", flush, 0);
    step(); idle();
    chk("R8", "E to S", st, 1);
    restart(); fill(A, 0, 0);
    snoop(2, A); step(); idle();
    chk("R8", "E upgr to I", st, 0);
    restart(); fill(A, 0, 1);
    snoop(1, A);
    chk("R8", "S rdx no flush", flush, 0);
    step(); idle();
    chk("R8", "S rdx to I", st, 0);
  endtask

  task automatic t_snoop_other();
    restart(); fill(A, 1, 0);
    snoop(1, B);
    chk("R9", "no flush other addr", flush, 0);
    step(); idle();
    chk("R9", "M unchanged", st, 3);
    restart(); fill(A, 0, 1);
    cpu_wr = 1; cpu_addr = A; step();
    snoop(1, B); step(); snp_valid = 0;
    chk("R9", "upgrade pending unchanged", st, 6);
    chk("R9", "cmd unchanged", bus_cmd, 2);
    idle();
  endtask

  task automatic t_evict();
    restart(); fill(A, 1, 0);
    cpu_rd = 1; cpu_addr = B; step();
    chk("R10", "wb pending", st, 7);
    chk("R10", "wb cmd", bus_cmd, 3);
    chk("R10", "wb addr old", bus_addr, A);
    bus_gnt = 1; #1;
    chk("R10", "flush on wb grant", flush, 1);
    chk("R10", "no done on wb", cpu_done, 0);
    step(); bus_gnt = 0; #1;
    chk("R10", "fetch pending", st, 4);
    chk("R10", "fetch addr", bus_addr, B);
    chk("R10", "fetch cmd", bus_cmd, 0);
    bus_gnt = 1; bus_shared = 1; #1;
    chk("R10", "done on fetch", cpu_done, 1);
    step(); idle();
    chk("R10", "new line S", st, 1);
  endtask

  task automatic t_wb_snoop();
    restart(); fill(A, 1, 0);
    cpu_wr = 1; cpu_addr = B; step();
    snoop(0, A);
    chk("R11", "flush while waiting", flush, 1);
    step(); snp_valid = 0; #1;
    chk("R11", "skip wb to write pending", st, 5);
    chk("R11", "new addr", bus_addr, B);
    bus_gnt = 1; step(); idle();
    chk("R11", "write miss done to M", st, 3);
  endtask

  task automatic t_livelock();
    restart();
    cpu_wr = 1; cpu_addr = A; step();
    bus_gnt = 1; #1;
    chk("R12", "write commits on grant", cpu_done, 1);
    step(); idle();
    snoop(1, A);
    chk("R12", "next-cycle snoop flushes", flush, 1);
    step(); idle();
    chk("R12", "line given up after write", st, 0);
  endtask

  initial begin
    idle();
    t_reset();
    t_read_miss(0);
    t_read_miss(1);
    t_hits();
    t_upgrade();
    t_upgrade_lost(1);
    t_upgrade_lost(2);
    t_write_miss();
    t_snoop_m();
    t_snoop_se();
    t_snoop_other();
    t_evict();
    t_wb_snoop();
    t_livelock();
    if (!ended) begin
      ended = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!ended) begin
      ended = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule